// File: doc/BRIEF.md
# Per-Level Switching Transition Counter

This block watches the gate command bits of one phase leg of a multilevel inverter and counts how often each level's device pair switches during one modulation period. Each gate bit drives one complementary device pair, so a change of that bit is one switching event for the level. Turn-on and turn-off edges are counted in separate counters for every level. At the end of the period the counts, their per-level sums and the leg total are reported together.

A controller drives a one-clock strobe at the start of each modulation cycle, which is the reciprocal of the reference frequency. At that strobe the running counts are copied into output registers and the counters start again. A done flag then pulses for one clock. With the latched figures the controller can try carrier displacement angles or per-band carrier frequencies and keep the setting that gives the fewest switchings or the most even spread. When every band shares one carrier frequency, the outermost pairs usually switch more often than the inner ones, and the per-level breakdown shows this directly.

Top module: `sw_level_counter`

## Requirements
- R1: While reset is asserted and after it is released until the first strobe, every count output is zero and done is low.
- R2: The first gate sample taken after reset release is never counted as an edge. Gate bits that are already high at release and then stay high give a rise count of zero.
- R3: A 0-to-1 change of gate bit i (bit 0 = lowest level pair, bit LEVELS-2 = highest) between two consecutive clocks adds one to that level's rise count and to nothing else.
- R4: A 1-to-0 change of gate bit i adds one to that level's fall count only.
- R5: For each level, the latched level output equals the latched rise count plus the latched fall count, at width CNT_W+1.
- R6: The latched total equals the sum of all latched rise and fall counts over every level.
- R7: A strobe latches the edges of the clocks after the previous strobe (or after reset), up to and including the clock before this strobe. An edge that occurs in the strobe clock itself belongs to the next window. The latched values appear one clock after the strobe.
- R8: Done is high for exactly one clock after each strobe, so back-to-back strobes give back-to-back done. Outputs do not change between strobes.
- R9: Each rise and each fall counter saturates at 2^CNT_W-1 (1023 by default) and holds there until the next strobe.
- R10: For a six-level leg with pulse trains giving 8, 6, 6, 6, 8 transitions from the lowest level to the highest, the latched level outputs are 8, 6, 6, 6, 8 and the total is 34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | LEVELS-1 | Gate command bits, bit 0 = lowest level pair |
| cyc_strobe_i | input | 1 | One-clock pulse at the start of a modulation cycle |
| rise_cnt_o | output | (LEVELS-1)*CNT_W | Latched 0-to-1 counts, level i at bits [i*CNT_W +: CNT_W] |
| fall_cnt_o | output | (LEVELS-1)*CNT_W | Latched 1-to-0 counts, same packing |
| lvl_cnt_o | output | (LEVELS-1)*(CNT_W+1) | Latched per-level sum of rise and fall |
| total_o | output | CNT_W+1+clog2(LEVELS-1) | Latched sum of all transitions of the leg |
| done_o | output | 1 | One-clock pulse when new results are latched |

## Verification
The hardest cases to reach from the ports are the window boundary and saturation. For the boundary, the stimulus places a gate edge in the very clock that carries the strobe and then confirms that this edge shows up only in the following window. It also issues strobes on consecutive clocks, so that one window is only one clock long. For saturation, one level is toggled on every clock for more than two thousand clocks, which drives both of its counters past 1023 inside a single window. A reset released with all gates high exercises the rule that the first sample is ignored.

// File: rtl/sw_cnt_pkg.sv
package sw_cnt_pkg;

  function automatic int clog2_int(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  // width of the leg total: 2 * devices * max count
  function automatic int total_width(input int num_dev, input int cnt_w);
    return cnt_w + 1 + clog2_int(num_dev);
  endfunction

endpackage

// File: rtl/sw_edge_det.sv
module sw_edge_det #(
  parameter int NUM_DEV = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] gate_i,
  output logic [NUM_DEV-1:0] rise_o,
  output logic [NUM_DEV-1:0] fall_o
);

  logic [NUM_DEV-1:0] gate_q, gate_d;
  logic               primed_q, primed_d;
  logic               smp_en;

  assign smp_en = 1'b1;

  always_comb begin
    gate_d   = gate_q;
    primed_d = primed_q;
    if (smp_en) begin
      gate_d   = gate_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      gate_q   <= gate_d;
      primed_q <= primed_d;
    end
  end

  always_comb begin
    rise_o = '0;
    fall_o = '0;
    if (primed_q) begin
      rise_o = gate_i & ~gate_q;
      fall_o = ~gate_i & gate_q;
    end
  end

  // R3: a reported rise leaves the stored copy high
  assert_rise_seen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((gate_q & $past(rise_o)) == $past(rise_o)));

  // R4: a reported fall leaves the stored copy low
  assert_fall_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o != '0) |=> ((gate_q & $past(fall_o)) == '0));

endmodule

// File: rtl/sw_lvl_ctr.sv
module sw_lvl_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] rise_cnt_o,
  output logic [CNT_W-1:0] fall_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rise_q, rise_d, fall_q, fall_d;
  logic [CNT_W-1:0] rise_base, fall_base;
  logic             rise_en, fall_en;

  assign rise_en = strobe_i | rise_i;
  assign fall_en = strobe_i | fall_i;

  always_comb begin
    rise_base = strobe_i ? '0 : rise_q;
    fall_base = strobe_i ? '0 : fall_q;
    rise_d    = rise_base;
    fall_d    = fall_base;
    if (rise_i && (rise_base != CNT_MAX)) rise_d = rise_base + 1'b1;
    if (fall_i && (fall_base != CNT_MAX)) fall_d = fall_base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (rise_en) rise_q <= rise_d;
      if (fall_en) fall_q <= fall_d;
    end
  end

  assign rise_cnt_o = rise_q;
  assign fall_cnt_o = fall_q;

  // R9: a full counter stays full inside a window
  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && rise_q == CNT_MAX) |=> (rise_q == CNT_MAX));

  // R3: inside a window the count moves by at most one
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ((rise_q == $past(rise_q)) || (rise_q == $past(rise_q) + 1'b1)));

  // R7: a strobe restarts the window with at most the strobe-clock edge
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (fall_q <= 1));

endmodule

// File: rtl/sw_latch.sv
module sw_latch
  import sw_cnt_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int CNT_W   = 10,
  localparam int LVL_W  = CNT_W + 1,
  localparam int TOT_W  = total_width(NUM_DEV, CNT_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [NUM_DEV*CNT_W-1:0] live_rise_i,
  input  logic [NUM_DEV*CNT_W-1:0] live_fall_i,
  output logic [NUM_DEV*CNT_W-1:0] rise_o,
  output logic [NUM_DEV*CNT_W-1:0] fall_o,
  output logic [NUM_DEV*LVL_W-1:0] lvl_o,
  output logic [TOT_W-1:0]         total_o,
  output logic                     done_o
);

  logic [NUM_DEV*CNT_W-1:0] rise_q, fall_q;
  logic [NUM_DEV*LVL_W-1:0] lvl_q, lvl_d;
  logic [TOT_W-1:0]         total_q, total_d;
  logic                     done_q, done_d;

  always_comb begin
    total_d = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      lvl_d[i*LVL_W +: LVL_W] = {1'b0, live_rise_i[i*CNT_W +: CNT_W]}
                              + {1'b0, live_fall_i[i*CNT_W +: CNT_W]};
      total_d = total_d + TOT_W'(live_rise_i[i*CNT_W +: CNT_W])
                        + TOT_W'(live_fall_i[i*CNT_W +: CNT_W]);
    end
    done_d = strobe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      fall_q  <= '0;
      lvl_q   <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (strobe_i) begin
        rise_q  <= live_rise_i;
        fall_q  <= live_fall_i;
        lvl_q   <= lvl_d;
        total_q <= total_d;
      end
    end
  end

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign lvl_o   = lvl_q;
  assign total_o = total_q;
  assign done_o  = done_q;

  logic [TOT_W-1:0] lvl_sum_chk;
  always_comb begin
    lvl_sum_chk = '0;
    for (int i = 0; i < NUM_DEV; i++)
      lvl_sum_chk = lvl_sum_chk + TOT_W'(lvl_q[i*LVL_W +: LVL_W]);
  end

  // R6: total agrees with the latched per-level sums
  assert_total_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (total_o == lvl_sum_chk));

  // R8: done only follows a strobe
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !done_o);

  // R8: results hold between strobes
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(total_o) && $stable(lvl_o)));

endmodule

// File: rtl/sw_level_counter.sv
module sw_level_counter
  import sw_cnt_pkg::*;
#(
  parameter int LEVELS   = 6,
  parameter int CNT_W    = 10,
  localparam int NUM_DEV = LEVELS - 1,
  localparam int LVL_W   = CNT_W + 1,
  localparam int TOT_W   = total_width(NUM_DEV, CNT_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DEV-1:0]       gate_i,
  input  logic                     cyc_strobe_i,
  output logic [NUM_DEV*CNT_W-1:0] rise_cnt_o,
  output logic [NUM_DEV*CNT_W-1:0] fall_cnt_o,
  output logic [NUM_DEV*LVL_W-1:0] lvl_cnt_o,
  output logic [TOT_W-1:0]         total_o,
  output logic                     done_o
);

  logic [NUM_DEV-1:0]       rise_ev, fall_ev;
  logic [NUM_DEV*CNT_W-1:0] live_rise, live_fall;

  sw_edge_det #(.NUM_DEV(NUM_DEV)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_lvl
    sw_lvl_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .strobe_i   (cyc_strobe_i),
      .rise_i     (rise_ev[g]),
      .fall_i     (fall_ev[g]),
      .rise_cnt_o (live_rise[g*CNT_W +: CNT_W]),
      .fall_cnt_o (live_fall[g*CNT_W +: CNT_W])
    );
  end

  sw_latch #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) latch_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (cyc_strobe_i),
    .live_rise_i (live_rise),
    .live_fall_i (live_fall),
    .rise_o      (rise_cnt_o),
    .fall_o      (fall_cnt_o),
    .lvl_o       (lvl_cnt_o),
    .total_o     (total_o),
    .done_o      (done_o)
  );

  // R1: nothing is reported before the first strobe after reset
  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cyc_strobe_i));

endmodule

// File: tb/sw_level_counter_tb.sv
`timescale 1ns/1ps
module sw_level_counter_tb_top;

  localparam int LEVELS  = 6;
  localparam int CNT_W   = 10;
  localparam int NUM_DEV = LEVELS - 1;
  localparam int LVL_W   = CNT_W + 1;
  localparam int TOT_W   = CNT_W + 1 + 3;
  localparam int MAXC    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni;
  logic [NUM_DEV-1:0] gate;
  logic strobe;
  logic [NUM_DEV*CNT_W-1:0] rise_cnt, fall_cnt;
  logic [NUM_DEV*LVL_W-1:0] lvl_cnt;
  logic [TOT_W-1:0] total;
  logic done;

  always #10 clk = ~clk;

  sw_level_counter #(.LEVELS(LEVELS), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .gate_i(gate), .cyc_strobe_i(strobe),
    .rise_cnt_o(rise_cnt), .fall_cnt_o(fall_cnt), .lvl_cnt_o(lvl_cnt),
    .total_o(total), .done_o(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int    exp_r_q[$];
  int    exp_f_q[$];
  string tag_q[$];

  int mr[NUM_DEV];
  int mf[NUM_DEV];
  logic [NUM_DEV-1:0] prev;
  bit primed;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one clock of stimulus, expected window pushed on a strobe
  task automatic step(input logic [NUM_DEV-1:0] v, input bit s, input string tag);
    gate   = v;
    strobe = s;
    if (s) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        exp_r_q.push_back(mr[i]);
        exp_f_q.push_back(mf[i]);
        mr[i] = 0;
        mf[i] = 0;
      end
      tag_q.push_back(tag);
    end
    if (primed) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (v[i] && !prev[i] && mr[i] < MAXC) mr[i]++;
        if (!v[i] && prev[i] && mf[i] < MAXC) mf[i]++;
      end
    end
    prev   = v;
    primed = 1'b1;
    @(negedge clk);
  endtask

  // monitor: compares on done, checks stability otherwise (R8)
  logic [NUM_DEV*CNT_W-1:0] sh_r = '0, sh_f = '0;
  logic [TOT_W-1:0] sh_t = '0;

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (done) begin
        if (tag_q.size() == 0) begin
          chk("R8", "unexpected done", 1, 0);
        end else begin
          string tg;
          int sum;
          tg  = tag_q.pop_front();
          sum = 0;
          for (int i = 0; i < NUM_DEV; i++) begin
            int er, ef;
            er = exp_r_q.pop_front();
            ef = exp_f_q.pop_front();
            sum += er + ef;
            chk(tg, $sformatf("R3 rise lvl%0d", i), int'(rise_cnt[i*CNT_W +: CNT_W]), er);
            chk(tg, $sformatf("R4 fall lvl%0d", i), int'(fall_cnt[i*CNT_W +: CNT_W]), ef);
            chk(tg, $sformatf("R5 sum lvl%0d", i), int'(lvl_cnt[i*LVL_W +: LVL_W]), er + ef);
          end
          chk(tg, "R6 total", int'(total), sum);
        end
        sh_r = rise_cnt;
        sh_f = fall_cnt;
        sh_t = total;
      end else begin
        chk("R8", "hold total", int'(total), int'(sh_t));
        chk("R8", "hold rise", int'(rise_cnt == sh_r), 1);
        chk("R8", "hold fall", int'(fall_cnt == sh_f), 1);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(100000 * 20);
    if (!finished) begin
      finished = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int p[NUM_DEV];
    rst_ni = 1'b0;
    gate   = '1;
    strobe = 1'b0;
    primed = 1'b0;
    prev   = '0;
    for (int i = 0; i < NUM_DEV; i++) begin mr[i] = 0; mf[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "total in reset", int'(total), 0);
    chk("R1", "rise in reset", int'(rise_cnt == '0), 1);
    rst_ni = 1'b1;
    // R2: gates high at release and steady: no rise counted
    for (int k = 0; k < 5; k++) step('1, 0, "");
    chk("R1", "done before strobe", int'(done), 0);
    chk("R1", "total before strobe", int'(total), 0);
    step('1, 1, "R2");
    // R4: all bits fall once
    step('0, 0, "");
    step('0, 0, "");
    step('0, 1, "R4");
    // R10: 4,3,3,3,4 pulses -> 8,6,6,6,8 transitions, total 34
    p = '{4, 3, 3, 3, 4};
    for (int l = 0; l < NUM_DEV; l++) begin
      for (int n = 0; n < p[l]; n++) begin
        repeat (3) step(NUM_DEV'(1) << l, 0, "");
        repeat (3) step('0, 0, "");
      end
    end
    step('0, 1, "R10");
    // R3 then R7: edge inside the strobe clock goes to the next window
    step(5'b00100, 0, "");
    step(5'b00000, 1, "R3");
    step(5'b00000, 1, "R7");
    // R8: back-to-back strobes, one-clock windows
    step(5'b00001, 1, "R8");
    step(5'b00000, 1, "R8");
    step(5'b00000, 0, "");
    step(5'b00000, 1, "R8");
    // R5/R6: pseudo-random gate patterns
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[NUM_DEV-1:0], 0, "");
    end
    step('0, 1, "R5 R6 random");
    // R9: level 0 toggles every clock, level 4 slowly
    for (int k = 0; k < 2100; k++) step({(k % 6) < 3 ? 1'b1 : 1'b0, 3'b000, k[0]}, 0, "");
    step('0, 1, "R9");
    repeat (3) step('0, 0, "");
    chk("R8", "pending windows", tag_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule